// File: doc/BRIEF.md
# Transmit Byte FIFO with Packet Tags

This block is the holding store between a processor-side writer and a transmit packet processor. It keeps up to 256 bytes. Every byte is stored with a two-bit tag. One tag bit marks the last byte of a packet and the other marks a packet that must be aborted. The writer pushes one byte per cycle. The reader sees the oldest entry on its output whenever the store holds data, and pops it with a read strobe.

The block keeps a write pointer, a read pointer and a fill count. From these it derives empty, full and a space-available flag. Space-available compares the number of free entries against a threshold that software supplies. A write that arrives when no entry is free is dropped and raises a sticky overflow flag. A read that arrives when the store holds nothing raises a sticky underflow flag. Each sticky flag stays set until a one-cycle clear pulse removes it. The whole block runs on a single clock with a synchronous active-low reset.

Top module: `pbf_top`

## Requirements
- R1: After reset the block shows empty=1, full=0, fill_level=0, ovf_flag=0 and unf_flag=0.
- R2: Bytes and tags come out in the order they were written. While empty=0, rd_data, rd_eop and rd_abort show the oldest stored entry. rd_eop is tag bit 0 (end of packet) and rd_abort is tag bit 1 (aborted packet).
- R3: An accepted write adds one to fill_level and an accepted read subtracts one. A cycle that accepts both leaves fill_level unchanged. The new value is visible in the cycle after the strobe.
- R4: empty is 1 exactly when fill_level is 0.
- R5: full is 1 exactly when fill_level is 256.
- R6: space_avail is 1 exactly when (256 - fill_level) >= avail_thresh. A threshold of 0 holds it at 1, and a threshold above 256 holds it at 0.
- R7: A write while full is discarded. It leaves the stored bytes and fill_level unchanged, and ovf_flag is 1 from the next cycle on.
- R8: A read while empty pops nothing. It leaves fill_level at 0, and unf_flag is 1 from the next cycle on.
- R9: ovf_flag and unf_flag stay at 1 until a cycle with ovf_clr or unf_clr set, respectively. If a new event and its clear arrive in the same cycle, the flag stays at 1.
- R10: When full, a cycle with both strobes accepts the read and drops the write with overflow. When empty, a cycle with both strobes accepts the write and reports underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to store |
| wr_eop | input | 1 | Tag: last byte of packet |
| wr_abort | input | 1 | Tag: packet aborted |
| rd_en | input | 1 | Read (pop) strobe |
| rd_data | output | 8 | Oldest stored byte |
| rd_eop | output | 1 | Tag of oldest entry: end of packet |
| rd_abort | output | 1 | Tag of oldest entry: aborted |
| avail_thresh | input | 9 | Free-entry threshold for space_avail |
| ovf_clr | input | 1 | Clear pulse for ovf_flag |
| unf_clr | input | 1 | Clear pulse for unf_flag |
| empty | output | 1 | No entry stored |
| full | output | 1 | No entry free |
| space_avail | output | 1 | Free entries at or above threshold |
| fill_level | output | 9 | Number of stored entries, 0 to 256 |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
The hardest case is a push and a pop in the same cycle, above all at the two edges. At full, the pop must succeed while the push is dropped and flagged. At empty, the push must land while the pop is flagged. The bench fills the store to 256 entries and drains it to 0, then strobes both inputs together at each edge. Long random runs add many more coincident strobes, along with clear pulses that meet new events. A queue model is updated on every clock and judges each outcome, comparing fill level, flags and head entry on the following falling edge.

// File: rtl/pbf_pkg.sv
// Shared types for the packet byte FIFO.
package pbf_pkg;
    // Tag stored with each byte: bit 0 end of packet, bit 1 aborted packet.
    typedef struct packed {
        logic abort;
        logic eop;
    } pbf_tag_t;
endpackage

// File: rtl/pbf_mem.sv
// Storage array for tagged bytes. Writes are synchronous, and the entry at
// raddr is read combinationally. Assumes the controller never writes while full.
module pbf_mem #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int ENT_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [ENT_W-1:0]  wentry,
    input  logic [PTR_W-1:0]  raddr,
    output logic [ENT_W-1:0]  rentry
);
    logic [ENT_W-1:0] store [DEPTH];

    // Write one entry per accepted push.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wentry;
    end

    // Present the entry at the read pointer.
    always_comb rentry = store[raddr];
endmodule

// File: rtl/pbf_status.sv
// Derives empty, full and space-available from the fill count.
// Assumes fill never exceeds DEPTH.
module pbf_status #(
    parameter int DEPTH  = 256,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] thresh,
    output logic             empty,
    output logic             full,
    output logic             space_avail
);
    logic [CNT_W-1:0] free_cnt;

    // Compare the free entries and the fill against their limits.
    always_comb begin
        free_cnt    = CNT_W'(DEPTH) - fill;
        empty       = (fill == '0);
        full        = (fill == CNT_W'(DEPTH));
        space_avail = (free_cnt >= thresh);
    end
endmodule

// File: rtl/pbf_ctrl.sv
// Pointer, count and sticky-flag controller. Gates the strobes with
// full/empty and latches overflow and underflow. DEPTH must be a power of two.
module pbf_ctrl #(
    parameter int DEPTH  = 256,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             ovf_clr,
    input  logic             unf_clr,
    input  logic             empty,
    input  logic             full,
    output logic             wr_acc,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] fill,
    output logic             ovf_flag,
    output logic             unf_flag
);
    logic rd_acc;
    logic ovf_evt;
    logic unf_evt;

    // Decide which strobes are honoured and which raise events.
    always_comb begin
        wr_acc  = wr_en && !full;
        rd_acc  = rd_en && !empty;
        ovf_evt = wr_en && full;
        unf_evt = rd_en && empty;
    end

    // Advance the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_acc) wr_ptr <= wr_ptr + PTR_W'(1);
            if (rd_acc) rd_ptr <= rd_ptr + PTR_W'(1);
            case ({wr_acc, rd_acc})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
        end
    end

    // Sticky event flags; a new event wins over its clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            if (ovf_evt)      ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
            if (unf_evt)      unf_flag <= 1'b1;
            else if (unf_clr) unf_flag <= 1'b0;
        end
    end

    // R3
    fill_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full && !(rd_en && !empty)) |=> fill == $past(fill) + CNT_W'(1));
    // R3
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !full && !empty) |=> $stable(fill));
    // R5
    full_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (wr_ptr == rd_ptr));
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> ($stable(fill) && $stable(wr_ptr) && ovf_flag));
    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> (fill == '0 && $stable(rd_ptr) && unf_flag));
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
    // R9
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_flag && !unf_clr) |=> unf_flag);
endmodule

// File: rtl/pbf_top.sv
// Tagged transmit byte FIFO: storage, controller and status logic.
// Single clock, synchronous active-low reset, show-ahead read port.
module pbf_top #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1,
    localparam int ENT_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eop,
    input  logic              wr_abort,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eop,
    output logic              rd_abort,
    input  logic [CNT_W-1:0]  avail_thresh,
    input  logic              ovf_clr,
    input  logic              unf_clr,
    output logic              empty,
    output logic              full,
    output logic              space_avail,
    output logic [CNT_W-1:0]  fill_level,
    output logic              ovf_flag,
    output logic              unf_flag
);
    import pbf_pkg::*;

    logic             wr_acc;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [ENT_W-1:0] wentry;
    logic [ENT_W-1:0] rentry;
    pbf_tag_t         wtag;
    pbf_tag_t         rtag;

    // Pack the incoming byte with its tag and unpack the head entry.
    always_comb begin
        wtag.eop   = wr_eop;
        wtag.abort = wr_abort;
        wentry     = {wtag, wr_data};
        rtag       = pbf_tag_t'(rentry[ENT_W-1:DATA_W]);
        rd_data    = rentry[DATA_W-1:0];
        rd_eop     = rtag.eop;
        rd_abort   = rtag.abort;
    end

    pbf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .ovf_clr(ovf_clr), .unf_clr(unf_clr), .empty(empty), .full(full),
        .wr_acc(wr_acc), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .fill(fill_level),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    pbf_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .we(wr_acc), .waddr(wr_ptr), .wentry(wentry),
        .raddr(rd_ptr), .rentry(rentry)
    );

    pbf_status #(.DEPTH(DEPTH)) u_status (
        .fill(fill_level), .thresh(avail_thresh), .empty(empty),
        .full(full), .space_avail(space_avail)
    );

    // R4
    empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (fill_level == '0));
    // R2
    head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !rd_en) |=> $stable(rd_data));
endmodule

// File: tb/pbf_top_tb.sv
module pbf_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_eop = 1'b0, wr_abort = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [8:0] avail_thresh = 9'd16;
    logic       ovf_clr = 1'b0, unf_clr = 1'b0;
    logic [7:0] rd_data;
    logic       rd_eop, rd_abort, empty, full, space_avail, ovf_flag, unf_flag;
    logic [8:0] fill_level;

    int n_checks = 0;
    int n_fail = 0;
    bit [9:0] q[$];
    bit m_ovf = 0, m_unf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbf_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_eop(wr_eop), .wr_abort(wr_abort), .rd_en(rd_en),
        .rd_data(rd_data), .rd_eop(rd_eop), .rd_abort(rd_abort),
        .avail_thresh(avail_thresh), .ovf_clr(ovf_clr), .unf_clr(unf_clr),
        .empty(empty), .full(full), .space_avail(space_avail),
        .fill_level(fill_level), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model; called away from the clock edge.
    task automatic compare();
        int sz = q.size();
        chk("R3 fill_level", int'(fill_level), sz);
        chk("R4 empty", int'(empty), int'(sz == 0));
        chk("R5 full", int'(full), int'(sz == DEPTH));
        chk("R6 space_avail", int'(space_avail), int'((DEPTH - sz) >= int'(avail_thresh)));
        chk("R7 ovf_flag", int'(ovf_flag), int'(m_ovf));
        chk("R8 unf_flag", int'(unf_flag), int'(m_unf));
        if (sz != 0) chk("R2 head", int'({rd_abort, rd_eop, rd_data}), int'(q[0]));
    endtask

    // Apply one cycle of stimulus, update the model at the edge, then compare.
    task automatic step(bit w, bit [7:0] d, bit eop, bit ab, bit r, bit oc, bit uc);
        int sz;
        bit wa, ra;
        wr_en = w; wr_data = d; wr_eop = eop; wr_abort = ab;
        rd_en = r; ovf_clr = oc; unf_clr = uc;
        @(posedge clk);
        sz = q.size();
        wa = w && sz < DEPTH;
        ra = r && sz > 0;
        if (ra) void'(q.pop_front());
        if (wa) q.push_back({ab, eop, d});
        if (w && !wa) m_ovf = 1; else if (oc) m_ovf = 0;
        if (r && sz == 0) m_unf = 1; else if (uc) m_unf = 0;
        @(negedge clk);
        wr_en = 0; rd_en = 0; ovf_clr = 0; unf_clr = 0;
        compare();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 fill", int'(fill_level), 0);
        chk("R1 flags", int'({ovf_flag, unf_flag}), 0);
        // R8 read while empty, then R9 clear
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        // R2 short packets with tags, then drain
        for (int i = 0; i < 6; i++) step(1, 8'(8'h30 + i), i == 2 || i == 5, i == 5, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(1, 8'(8'h80 + i), 0, 0, 1, 0, 0); // R3 both strobes
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 0, 0);
        // R10 both strobes at empty
        step(1, 8'hA5, 1, 0, 1, 0, 0);
        // R6 thresholds while filling to full
        avail_thresh = 9'd0;
        for (int i = 0; i < 120; i++) step(1, 8'(i * 7), i % 9 == 0, i % 31 == 0, 0, 0, 0);
        avail_thresh = 9'd100;
        for (int i = 0; i < 140; i++) step(1, 8'(i * 3 + 1), i % 5 == 0, 0, 0, 0, 0);
        // R7 write while full, R9 clear together with a new event
        step(1, 8'hEE, 1, 1, 0, 0, 0);
        step(1, 8'hEF, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        // R10 both strobes at full
        step(1, 8'h11, 0, 1, 1, 0, 0);
        avail_thresh = 9'd300;
        step(0, 0, 0, 0, 0, 0, 0);
        avail_thresh = 9'd256;
        for (int i = 0; i < 260; i++) step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // Random mixed traffic
        avail_thresh = 9'd40;
        for (int i = 0; i < 6000; i++) begin
            int mode = (i / 500) % 3;
            bit w = ($urandom % 100) < (mode == 0 ? 70 : (mode == 1 ? 30 : 50));
            bit r = ($urandom % 100) < (mode == 0 ? 30 : (mode == 1 ? 70 : 50));
            step(w, 8'($urandom), 1'($urandom), 1'($urandom), r,
                 ($urandom % 8) == 0, ($urandom % 8) == 0);
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule